// File: doc/BRIEF.md
# Periodic Millisecond Interrupt Generator

This block produces a periodic interrupt request from an externally kept, free-running millisecond time value. Whenever a time strobe arrives, the current time is compared against a scheduled deadline. If the deadline has been reached, a pending request is raised and the deadline moves forward by a programmable 16-bit interval. If the time jumped far enough that the advanced deadline is still not in the future, the deadline is rebased to the current time plus the interval. As a result, a gap in the strobes yields a single request rather than a burst.

The request stays pending until the processor acknowledges it. A 16-bit handler address register is always presented on an output, ready for the interrupt acknowledge cycle. The interval, the handler address and the enable are loaded through simple one-cycle write ports. All time arithmetic is modular over 32 bits, so the counter may wrap.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset `irq_req` is 0, `vec_addr` is 0xFC00, the interval is 100 ms, and requests are disabled.
- R2: A `vec_wr` pulse loads `vec_din`, and the new value appears on `vec_addr` in the following cycle.
- R3: An `en_wr` pulse with `en_val`=1 arms the block, sets the deadline to `time_ms` plus the interval, and clears any pending request in the following cycle. This happens regardless of whether the block was already armed.
- R4: While the block is armed, a `time_strobe` cycle in which `time_ms` is at or past the deadline sets `irq_req` to 1 in the following cycle.
- R5: On a hit, the next deadline is the old deadline plus the interval, not the strobe time plus the interval. A late strobe therefore does not shift the period.
- R6: If the old deadline plus the interval is at or before the strobe time, the next deadline becomes the strobe time plus the interval. Missed periods never produce more than one request.
- R7: `irq_req` stays at 1 until an `irq_ack` pulse, which clears it in the following cycle. Further deadlines reached while a request is pending do not queue, so one acknowledge clears them all.
- R8: An `en_wr` pulse with `en_val`=0 clears `irq_req` in the following cycle. After that, no strobe raises a request until the block is armed again.
- R9: Time comparisons use signed 32-bit modular differences. When a deadline lies just past the wrap of `time_ms`, it is reached only once the wrapped time reaches it.
- R10: An `ivl_wr` pulse loads the interval for later deadline computations; the deadline already scheduled is not changed. A strobe or an arm in the same cycle as the write still uses the old interval.
- R11: Changes of `time_ms` without `time_strobe` have no effect on `irq_req` or on the schedule.
- R12: If a deadline is reached in the same cycle as `irq_ack`, `irq_req` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_ms | input | 32 | Free-running millisecond time |
| time_strobe | input | 1 | Compare time against deadline this cycle |
| en_wr | input | 1 | Write the enable |
| en_val | input | 1 | Enable value written by `en_wr` |
| ivl_wr | input | 1 | Write the interval register |
| ivl_din | input | 16 | New interval in milliseconds |
| vec_wr | input | 1 | Write the handler address register |
| vec_din | input | 16 | New handler address |
| irq_ack | input | 1 | Acknowledge pulse clearing the request |
| irq_req | output | 1 | Pending interrupt request |
| vec_addr | output | 16 | Handler address for the acknowledge cycle |

## Verification
The bench builds the block with its default parameters: a 16-bit interval resetting to 100 and a 16-bit handler address resetting to 0xFC00. It also uses the 32-bit time width fixed in the package. With these values, the reset interval can be measured directly, and arming the block a few dozen milliseconds before the 32-bit time wraps places the deadline on the far side of the wrap. Short intervals written during the run let random time jumps often exceed one or more periods, which exercises the rebase path alongside the normal advance.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    localparam int MS_W = 32;

    typedef logic [MS_W-1:0] ms_t;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_ARM  = 2'd1,
        ACT_STOP = 2'd2,
        ACT_FIRE = 2'd3
    } sched_act_e;

    typedef struct packed {
        logic armed;
        ms_t  deadline;
    } sched_state_t;

    // true when 'now' is at or past 'mark' (modular, signed difference)
    function automatic logic reached(input ms_t now, input ms_t mark);
        ms_t diff;
        diff = now - mark;
        return ~diff[MS_W-1];
    endfunction

    // true when 'a' lies strictly after 'b' (modular, signed difference)
    function automatic logic later(input ms_t a, input ms_t b);
        ms_t diff;
        diff = a - b;
        return (diff != '0) && ~diff[MS_W-1];
    endfunction

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
    import tick_irq_pkg::*;
#(
    parameter int          IVL_W   = 16,
    parameter int          VEC_W   = 16,
    parameter logic [15:0] IVL_RST = 16'd100,
    parameter logic [15:0] VEC_RST = 16'hFC00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ivl_wr,
    input  logic [IVL_W-1:0] ivl_din,
    input  logic             vec_wr,
    input  logic [VEC_W-1:0] vec_din,
    output logic [IVL_W-1:0] ivl_q,
    output logic [VEC_W-1:0] vec_q
);

    localparam logic [IVL_W-1:0] IVL_INIT = IVL_W'(IVL_RST);
    localparam logic [VEC_W-1:0] VEC_INIT = VEC_W'(VEC_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= IVL_INIT;
        end else if (ivl_wr) begin
            ivl_q <= ivl_din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= VEC_INIT;
        end else if (vec_wr) begin
            vec_q <= vec_din;
        end
    end

    p_vec_load_r2: assert property (@(posedge clk) disable iff (rst)
        vec_wr |=> (vec_q == $past(vec_din)));

    p_ivl_load_r10: assert property (@(posedge clk) disable iff (rst)
        ivl_wr |=> (ivl_q == $past(ivl_din)));

    p_vec_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!vec_wr && !$past(rst)) |=> $stable(vec_q));

endmodule

// File: rtl/tick_sched.sv
module tick_sched
    import tick_irq_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ms_t              now,
    input  logic             strobe,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic [IVL_W-1:0] ivl,
    output logic             fire,
    output logic             clr,
    output logic             armed
);

    sched_state_t st_q, st_d;
    sched_act_e   act;
    ms_t          ivl_ext;
    ms_t          step_dl;
    ms_t          rebase_dl;

    assign ivl_ext   = ms_t'(ivl);
    assign step_dl   = st_q.deadline + ivl_ext;
    assign rebase_dl = now + ivl_ext;

    always_comb begin
        if (en_wr) begin
            act = en_val ? ACT_ARM : ACT_STOP;
        end else if (st_q.armed && strobe && reached(now, st_q.deadline)) begin
            act = ACT_FIRE;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_ARM: begin
                st_d.armed    = 1'b1;
                st_d.deadline = rebase_dl;
            end
            ACT_STOP: begin
                st_d.armed = 1'b0;
            end
            ACT_FIRE: begin
                st_d.deadline = later(step_dl, now) ? step_dl : rebase_dl;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire  = (act == ACT_FIRE);
    assign clr   = (act == ACT_ARM) || (act == ACT_STOP);
    assign armed = st_q.armed;

    // after a hit with a nonzero interval the new deadline lies ahead of the strobe time
    p_deadline_ahead_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && ivl != '0) |=> later(st_q.deadline, $past(now)));

    p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !en_val) |=> !armed);

    p_arm_r3: assert property (@(posedge clk) disable iff (rst)
        (en_wr && en_val) |=> armed);

    p_no_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !en_wr) |=> $stable(st_q));

endmodule

// File: rtl/tick_pend.sv
module tick_pend (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic ack,
    input  logic clr,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (clr) begin
            pend <= 1'b0;
        end else if (fire) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack && !clr) |=> pend);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && !fire && !clr) |=> !pend);

    p_fire_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (fire && !clr) |=> pend);

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
    import tick_irq_pkg::*;
#(
    parameter int          IVL_W   = 16,
    parameter int          VEC_W   = 16,
    parameter logic [15:0] IVL_RST = 16'd100,
    parameter logic [15:0] VEC_RST = 16'hFC00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      time_ms,
    input  logic             time_strobe,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             ivl_wr,
    input  logic [IVL_W-1:0] ivl_din,
    input  logic             vec_wr,
    input  logic [VEC_W-1:0] vec_din,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] vec_addr
);

    logic [IVL_W-1:0] ivl_q;
    logic             fire;
    logic             clr;
    logic             armed;
    ms_t              now;

    assign now = ms_t'(time_ms);

    tick_cfg_regs #(
        .IVL_W   (IVL_W),
        .VEC_W   (VEC_W),
        .IVL_RST (IVL_RST),
        .VEC_RST (VEC_RST)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .ivl_wr  (ivl_wr),
        .ivl_din (ivl_din),
        .vec_wr  (vec_wr),
        .vec_din (vec_din),
        .ivl_q   (ivl_q),
        .vec_q   (vec_addr)
    );

    tick_sched #(
        .IVL_W (IVL_W)
    ) u_sched (
        .clk    (clk),
        .rst    (rst),
        .now    (now),
        .strobe (time_strobe),
        .en_wr  (en_wr),
        .en_val (en_val),
        .ivl    (ivl_q),
        .fire   (fire),
        .clr    (clr),
        .armed  (armed)
    );

    tick_pend u_pend (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .ack  (irq_ack),
        .clr  (clr),
        .pend (irq_req)
    );

    p_quiet_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !en_val) |=> !irq_req);

    p_arm_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (en_wr && en_val) |=> !irq_req);

    p_req_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(armed));

endmodule

// File: tb/tb_tick_irq_gen.sv
module tb_tick_irq_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] time_ms = '0;
    logic        time_strobe = 1'b0;
    logic        en_wr = 1'b0;
    logic        en_val = 1'b0;
    logic        ivl_wr = 1'b0;
    logic [15:0] ivl_din = '0;
    logic        vec_wr = 1'b0;
    logic [15:0] vec_din = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [15:0] vec_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    bit          m_en;
    logic [31:0] m_dl;
    bit          m_pend;
    logic [15:0] m_ivl;
    logic [15:0] m_vec;

    always #4 clk = ~clk;

    tick_irq_gen dut (
        .clk(clk), .rst(rst), .time_ms(time_ms), .time_strobe(time_strobe),
        .en_wr(en_wr), .en_val(en_val), .ivl_wr(ivl_wr), .ivl_din(ivl_din),
        .vec_wr(vec_wr), .vec_din(vec_din), .irq_ack(irq_ack),
        .irq_req(irq_req), .vec_addr(vec_addr)
    );

    function automatic bit at_or_past(logic [31:0] now, logic [31:0] mark);
        logic signed [31:0] d;
        d = signed'(now - mark);
        return d >= 0;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] nxt;
        bit hit;
        hit = 1'b0;
        if (en_wr) begin
            m_en = en_val;
            m_pend = 1'b0;
            if (en_val) m_dl = time_ms + 32'(m_ivl);
        end else if (m_en && time_strobe && at_or_past(time_ms, m_dl)) begin
            hit = 1'b1;
            m_pend = 1'b1;
            nxt = m_dl + 32'(m_ivl);
            if (at_or_past(time_ms, nxt)) nxt = time_ms + 32'(m_ivl);
            m_dl = nxt;
        end
        if (!en_wr && !hit && irq_ack) m_pend = 1'b0;
        if (ivl_wr) m_ivl = ivl_din;
        if (vec_wr) m_vec = vec_din;
    endtask

    // one clock: inputs already driven; update model, sample after edge, clear pulses
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        en_wr = 0; ivl_wr = 0; vec_wr = 0; irq_ack = 0; time_strobe = 0;
    endtask

    task automatic strobe_at(logic [31:0] t);
        time_ms = t; time_strobe = 1; cyc();
    endtask

    task automatic ack();
        irq_ack = 1; cyc();
    endtask

    task automatic expect_irq(bit e, string req);
        check(irq_req === e, req, 32'(irq_req), 32'(e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_en = 0; m_dl = 0; m_pend = 0; m_ivl = 16'd100; m_vec = 16'hFC00;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        expect_irq(0, "R1");
        check(vec_addr === 16'hFC00, "R1 vec", 32'(vec_addr), 32'hFC00);

        // R3 arm at 1000, R1 interval 100
        time_ms = 1000; en_wr = 1; en_val = 1; cyc();
        strobe_at(1099); expect_irq(0, "R1 interval");
        strobe_at(1100); expect_irq(1, "R4");
        ack(); expect_irq(0, "R7 ack");
        // R5 late strobe does not shift period
        strobe_at(1150); expect_irq(0, "R5");
        strobe_at(1205); expect_irq(1, "R5");
        ack();
        strobe_at(1299); expect_irq(0, "R5");
        strobe_at(1300); expect_irq(1, "R5 period kept");
        ack();
        // R6 rebase after missed periods
        strobe_at(1650); expect_irq(1, "R6");
        ack();
        strobe_at(1700); expect_irq(0, "R6 no burst");
        strobe_at(1749); expect_irq(0, "R6");
        strobe_at(1750); expect_irq(1, "R6 rebased");
        ack();
        // R7 no queueing
        strobe_at(1850); expect_irq(1, "R7");
        strobe_at(1950); expect_irq(1, "R7 held");
        ack(); expect_irq(0, "R7 single ack");
        // R11 time moves without strobe
        time_ms = 5000; cyc(); cyc(); expect_irq(0, "R11");
        strobe_at(2049); expect_irq(0, "R11 schedule kept");
        // R10 interval change keeps scheduled deadline 2050
        ivl_din = 10; ivl_wr = 1; cyc();
        strobe_at(2050); expect_irq(1, "R10");
        ack();
        strobe_at(2059); expect_irq(0, "R10 new interval");
        strobe_at(2060); expect_irq(1, "R10 new interval");
        ack();
        // R12 hit coincides with ack
        strobe_at(2070); expect_irq(1, "R12");
        time_ms = 2080; time_strobe = 1; irq_ack = 1; cyc();
        expect_irq(1, "R12 hit beats ack");
        ack(); expect_irq(0, "R12");
        // R8 disable
        strobe_at(2090); expect_irq(1, "R8");
        en_wr = 1; en_val = 0; cyc(); expect_irq(0, "R8 clear");
        strobe_at(3000); expect_irq(0, "R8 stopped");
        // R3 re-arm while pending
        time_ms = 3000; en_wr = 1; en_val = 1; cyc();
        strobe_at(3010); expect_irq(1, "R3");
        time_ms = 3015; en_wr = 1; en_val = 1; cyc(); expect_irq(0, "R3 clear");
        strobe_at(3024); expect_irq(0, "R3 rearm");
        strobe_at(3025); expect_irq(1, "R3 rearm");
        ack();
        // R9 wraparound
        ivl_din = 100; ivl_wr = 1; cyc();
        time_ms = 32'hFFFF_FFC0; en_wr = 1; en_val = 1; cyc();
        strobe_at(32'hFFFF_FFF0); expect_irq(0, "R9");
        strobe_at(32'h0000_0023); expect_irq(0, "R9");
        strobe_at(32'h0000_0024); expect_irq(1, "R9 wrapped");
        ack();
        // R2 vector load
        vec_din = 16'h1234; vec_wr = 1; cyc();
        check(vec_addr === 16'h1234, "R2", 32'(vec_addr), 32'h1234);

        // random phase against bench model
        time_ms = 32'h7FFF_FF00;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 45) begin
                time_ms = time_ms + 32'($urandom_range(0, 60));
                time_strobe = 1;
            end
            if ($urandom_range(0, 99) < 20) irq_ack = 1;
            if ($urandom_range(0, 99) < 3) begin
                ivl_wr = 1; ivl_din = 16'($urandom_range(0, 40));
            end
            if ($urandom_range(0, 99) < 2) begin
                en_wr = 1; en_val = ($urandom_range(0, 3) != 0);
            end
            if ($urandom_range(0, 99) < 2) begin
                vec_wr = 1; vec_din = 16'($urandom);
            end
            cyc();
            check(irq_req === m_pend, "R4 R5 R6 R7 random", 32'(irq_req), 32'(m_pend));
            check(vec_addr === m_vec, "R2 random", 32'(vec_addr), 32'(m_vec));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule